// File: doc/BRIEF.md
# Streaming Connected Component Labeler

The block labels the 4-connected black regions of an N×N binary image (N = 8 by default) that arrives one column per transfer. Columns are accepted rightmost first; each one enters the left edge of an internal pixel array while the array moves one place to the right. After the last column, the whole image sits in the array with image column c at array column c. Each pixel carries a record of three extents of its component: the rightmost column, the leftmost column and the topmost row. The records start at zero and are filled in by region-wide broadcasts over black neighbours.

Processing runs in three phases, each of N steps. During loading, the black pixels of each new column write that column's index into the leftmost-column field of their region. During the row sweep, the black pixels of each row whose upper neighbour is white write the row index into the topmost-row field of their region, but only where that field is still zero. During draining, the black pixels of the array's rightmost column whose rightmost-column field is still zero write their column index into their region's field. The column is then presented at the output and shifted out. A broadcast is carried out as a flood that grows one neighbour step per clock until it stops changing. Because of this, a step takes a number of cycles that depends on the data, and the input side signals when it can take the next column.

Top module: `ccl_labeler`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `in_ready` is high only while the block waits for the next column of a frame. It drops for at least one cycle after each accepted column (`in_valid` and `in_ready` both high at a clock edge). It stays low from the N-th accepted column until the last output column of that frame has been presented.
- R3: Each frame produces exactly N single-cycle `out_valid` pulses, never on back-to-back cycles. The first pulse carries image column N and the following pulses descend to column 1. `out_pix` bit r equals the input pixel of row r+1 in that column, where `in_col` bit r is row r+1 (row 1 is the top) and 1 means black.
- R4: A white output pixel carries an all-zero record.
- R5: A black output pixel's leftmost-column field equals the smallest 1-based column index of its 4-connected component. Each field is W = ceil(log2(N+1)) bits, and row r's field occupies bits [r*W +: W] of its output bus.
- R6: A black output pixel's rightmost-column field equals the largest 1-based column index of its component. This holds even when the part of the component still in the array has been split by earlier outputs.
- R7: A black output pixel's topmost-row field equals the smallest 1-based row index of its component.
- R8: Connectivity uses only north, south, east and west neighbours; diagonally touching pixels belong to different components.
- R9: A frame's labels do not depend on any earlier frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A column is offered on `in_col` |
| in_col | input | N | Pixel column, bit r = row r+1, 1 = black |
| in_ready | output | 1 | The block takes the offered column at this edge |
| out_valid | output | 1 | An output column is presented this cycle |
| out_pix | output | N | Output pixels, bit r = row r+1 |
| out_rc | output | N*W | Rightmost-column field per row |
| out_lc | output | N*W | Leftmost-column field per row |
| out_tr | output | N*W | Topmost-row field per row |

## Verification
The test frames are an empty image, a full image, a checkerboard, two U shapes, a serpentine and a scattered mix. The checkerboard has only diagonal contacts, so it separates 4-connectivity from 8-connectivity. The U that closes on the left checks that a late left edge overwrites the leftmost field across both arms. The U that closes on the right checks that the rightmost field reaches arms that become disconnected once the joining column has left. The serpentine forces long floods and tests the topmost-row field along a path that winds downward. An empty frame follows the full frame to show that nothing carries over between frames.

// File: rtl/ccl_pkg.sv
`timescale 1ns/1ps
// ccl_pkg: shared controller encodings for the streaming component labeler.
// Assumes nothing beyond the enum widths fixed here.
package ccl_pkg;
    typedef enum logic [1:0] {ST_WAIT, ST_SEED, ST_FLOOD, ST_EMIT} ccl_state_e;
    typedef enum logic [1:0] {PH_LOAD, PH_SWEEP, PH_DRAIN} ccl_phase_e;
endpackage

// File: rtl/ccl_flood.sv
`timescale 1ns/1ps
// ccl_flood: one growth step of a region flood over the black pixels of an
// N x N array (cell index r*N+c). Assumes the mask contains only black cells.
// done is high when a further step would not change the mask.
module ccl_flood #(
    parameter int N  = 8,
    localparam int NN = N * N
) (
    input  logic [NN-1:0] blk,
    input  logic [NN-1:0] mask,
    output logic [NN-1:0] grown,
    output logic          done
);
    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic nu, nd, nl, nr;
            if (r > 0) begin : g_u
                assign nu = mask[(r-1)*N+c];
            end else begin : g_nu
                assign nu = 1'b0;
            end
            if (r < N-1) begin : g_d
                assign nd = mask[(r+1)*N+c];
            end else begin : g_nd
                assign nd = 1'b0;
            end
            if (c > 0) begin : g_l
                assign nl = mask[r*N+c-1];
            end else begin : g_nl
                assign nl = 1'b0;
            end
            if (c < N-1) begin : g_r
                assign nr = mask[r*N+c+1];
            end else begin : g_nr
                assign nr = 1'b0;
            end
            // a black cell joins when any 4-neighbour is already flooded
            assign grown[r*N+c] = mask[r*N+c] | (blk[r*N+c] & (nu | nd | nl | nr));
        end
    end
    assign done = (grown == mask);
endmodule

// File: rtl/ccl_ctrl.sv
`timescale 1ns/1ps
// ccl_ctrl: sequences the load, sweep and drain phases, N steps each.
// Each step is seed -> flood until done -> (drain only) emit.
// Assumes flood_done is valid in ST_FLOOD.
module ccl_ctrl
    import ccl_pkg::*;
#(
    parameter int N  = 8,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       flood_done,
    output ccl_state_e state,
    output ccl_phase_e phase,
    output logic [SW-1:0] step,
    output logic       in_ready,
    output logic       out_valid
);
    localparam logic [SW-1:0] LAST = SW'(N - 1);

    assign in_ready  = (state == ST_WAIT);
    assign out_valid = (state == ST_EMIT);

    // phase/step state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            phase <= PH_LOAD;
            step  <= '0;
        end else begin
            case (state)
                ST_WAIT:  if (in_valid) state <= ST_SEED;
                ST_SEED:  state <= ST_FLOOD;
                ST_FLOOD: if (flood_done) begin
                    case (phase)
                        PH_LOAD: if (step == LAST) begin
                            phase <= PH_SWEEP;
                            step  <= '0;
                            state <= ST_SEED;
                        end else begin
                            step  <= step + 1'b1;
                            state <= ST_WAIT;
                        end
                        PH_SWEEP: if (step == LAST) begin
                            phase <= PH_DRAIN;
                            step  <= '0;
                            state <= ST_SEED;
                        end else begin
                            step  <= step + 1'b1;
                            state <= ST_SEED;
                        end
                        default: state <= ST_EMIT;
                    endcase
                end
                default: if (step == LAST) begin
                    phase <= PH_LOAD;
                    step  <= '0;
                    state <= ST_WAIT;
                end else begin
                    step  <= step + 1'b1;
                    state <= ST_SEED;
                end
            endcase
        end
    end

    // R3
    emit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/ccl_labeler.sv
`timescale 1ns/1ps
// ccl_labeler: streaming 4-connected component labeler. Holds the pixel
// array and the per-pixel extent records; the controller sequences the
// phases and ccl_flood performs region broadcasts one neighbour per clock.
// Assumes columns arrive rightmost first; output has no backpressure.
module ccl_labeler
    import ccl_pkg::*;
#(
    parameter int N  = 8,
    localparam int W  = $clog2(N + 1),
    localparam int NN = N * N,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   in_col,
    output logic           in_ready,
    output logic           out_valid,
    output logic [N-1:0]   out_pix,
    output logic [N*W-1:0] out_rc,
    output logic [N*W-1:0] out_lc,
    output logic [N*W-1:0] out_tr
);
    ccl_state_e    state;
    ccl_phase_e    phase;
    logic [SW-1:0] step;
    logic [NN-1:0] blk, mask, seed, grown;
    logic          done;
    logic [W-1:0]  lc_q [NN];
    logic [W-1:0]  rc_q [NN];
    logic [W-1:0]  tr_q [NN];
    logic [W-1:0]  wval;

    ccl_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flood_done(done),
        .state(state), .phase(phase), .step(step),
        .in_ready(in_ready), .out_valid(out_valid)
    );

    ccl_flood #(.N(N)) u_flood (
        .blk(blk), .mask(mask), .grown(grown), .done(done)
    );

    // broadcast sources for the current phase step
    for (genvar r = 0; r < N; r++) begin : g_sr
        for (genvar c = 0; c < N; c++) begin : g_sc
            logic top_edge;
            if (r == 0) begin : g_t0
                assign top_edge = 1'b1;
            end else begin : g_tn
                assign top_edge = !blk[(r-1)*N+c];
            end
            assign seed[r*N+c] = blk[r*N+c] & (
                (phase == PH_LOAD  && c == 0) ||
                (phase == PH_SWEEP && step == SW'(r) && top_edge) ||
                (phase == PH_DRAIN && c == N-1 && rc_q[r*N+c] == '0));
        end
    end

    // value broadcast in this step: row number in the sweep, column otherwise
    always_comb begin
        if (phase == PH_SWEEP) wval = W'(step) + W'(1);
        else                   wval = W'(N) - W'(step);
    end

    // array storage: shift on load/emit, flood growth, record writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk  <= '0;
            mask <= '0;
            for (int i = 0; i < NN; i++) begin
                lc_q[i] <= '0;
                rc_q[i] <= '0;
                tr_q[i] <= '0;
            end
        end else if ((state == ST_WAIT && in_valid) || state == ST_EMIT) begin
            for (int r = 0; r < N; r++) begin
                for (int c = N-1; c > 0; c--) begin
                    blk[r*N+c]  <= blk[r*N+c-1];
                    lc_q[r*N+c] <= lc_q[r*N+c-1];
                    rc_q[r*N+c] <= rc_q[r*N+c-1];
                    tr_q[r*N+c] <= tr_q[r*N+c-1];
                end
                blk[r*N]  <= (state == ST_WAIT) ? in_col[r] : 1'b0;
                lc_q[r*N] <= '0;
                rc_q[r*N] <= '0;
                tr_q[r*N] <= '0;
            end
        end else if (state == ST_SEED) begin
            mask <= seed;
        end else if (state == ST_FLOOD) begin
            if (!done) begin
                mask <= grown;
            end else begin
                for (int i = 0; i < NN; i++) begin
                    if (mask[i]) begin
                        case (phase)
                            PH_LOAD:  lc_q[i] <= wval;
                            PH_SWEEP: if (tr_q[i] == '0) tr_q[i] <= wval;
                            default:  rc_q[i] <= wval;
                        endcase
                    end
                end
            end
        end
    end

    // present the rightmost array column
    always_comb begin
        for (int r = 0; r < N; r++) begin
            out_pix[r]       = blk[r*N+N-1];
            out_rc[r*W +: W] = rc_q[r*N+N-1];
            out_lc[r*W +: W] = lc_q[r*N+N-1];
            out_tr[r*W +: W] = tr_q[r*N+N-1];
        end
    end

    // R8
    flood_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOOD) |-> ((mask & ~blk) == '0));

    for (genvar r = 0; r < N; r++) begin : g_chk
        // R4
        white_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_pix[r]) |->
            (out_rc[r*W +: W] == '0 && out_lc[r*W +: W] == '0 && out_tr[r*W +: W] == '0));
        // R5
        label_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_pix[r]) |->
            (out_lc[r*W +: W] != '0 && out_lc[r*W +: W] <= out_rc[r*W +: W] && out_tr[r*W +: W] != '0));
    end
endmodule

// File: tb/ccl_labeler_bench.sv
`timescale 1ns/1ps
// ccl_labeler_bench: drives image frames, computes labels with a BFS
// reference and compares every output column at the negative edge.
module ccl_labeler_bench;
    localparam int N = 8;
    localparam int W = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N-1:0] in_col = '0;
    logic in_ready, out_valid;
    logic [N-1:0] out_pix;
    logic [N*W-1:0] out_rc, out_lc, out_tr;

    int checks = 0;
    int errors = 0;
    int out_total = 0;
    int cyc = 0;

    bit img [N][N];
    int elc [N][N];
    int erc [N][N];
    int etr [N][N];
    int comp [N][N];

    ccl_labeler #(.N(N)) u_ccl_labeler (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
        .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix),
        .out_rc(out_rc), .out_lc(out_lc), .out_tr(out_tr)
    );

    always #2.5 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
            summary();
        end
    end

    // reference labels: BFS over 4-neighbours, 1-based extents
    task automatic reference();
        int q[$];
        int id;
        id = 0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                comp[r][c] = -1;
                elc[r][c] = 0; erc[r][c] = 0; etr[r][c] = 0;
            end
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                if (img[r][c] && comp[r][c] < 0) begin
                    int mnc, mxc, mnr;
                    int members[$];
                    mnc = N; mxc = -1; mnr = N;
                    comp[r][c] = id;
                    q.push_back(r * N + c);
                    while (q.size() > 0) begin
                        int p, pr, pc;
                        p = q.pop_front();
                        members.push_back(p);
                        pr = p / N; pc = p % N;
                        if (pc < mnc) mnc = pc;
                        if (pc > mxc) mxc = pc;
                        if (pr < mnr) mnr = pr;
                        for (int d = 0; d < 4; d++) begin
                            int nr, nc;
                            nr = pr + ((d == 0) ? -1 : (d == 1) ? 1 : 0);
                            nc = pc + ((d == 2) ? -1 : (d == 3) ? 1 : 0);
                            if (nr >= 0 && nr < N && nc >= 0 && nc < N)
                                if (img[nr][nc] && comp[nr][nc] < 0) begin
                                    comp[nr][nc] = id;
                                    q.push_back(nr * N + nc);
                                end
                        end
                    end
                    foreach (members[k]) begin
                        elc[members[k] / N][members[k] % N] = mnc + 1;
                        erc[members[k] / N][members[k] % N] = mxc + 1;
                        etr[members[k] / N][members[k] % N] = mnr + 1;
                    end
                    id++;
                end
    endtask

    // per-clock comparison of presented columns
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int col;
            col = N - 1 - (out_total % N);
            checks++;
            if (in_ready) begin
                errors++;
                $display("FAIL R2: in_ready act=1 exp=0 during output");
            end
            for (int r = 0; r < N; r++) begin
                int ap, al, ar, at;
                ap = int'(out_pix[r]);
                al = int'(out_lc[r*W +: W]);
                ar = int'(out_rc[r*W +: W]);
                at = int'(out_tr[r*W +: W]);
                checks++;
                if (ap != int'(img[r][col]) || al != elc[r][col] ||
                    ar != erc[r][col] || at != etr[r][col]) begin
                    errors++;
                    $display("FAIL %s: row %0d col %0d act pix=%0d rc=%0d lc=%0d tr=%0d exp pix=%0d rc=%0d lc=%0d tr=%0d",
                        (ap != int'(img[r][col])) ? "R3" :
                        (!img[r][col]) ? "R4" :
                        (al != elc[r][col]) ? "R5" :
                        (ar != erc[r][col]) ? "R6" : "R7",
                        r + 1, col + 1, ap, ar, al, at,
                        int'(img[r][col]), erc[r][col], elc[r][col], etr[r][col]);
                end
            end
            out_total <= out_total + 1;
        end
    end

    task automatic send_frame(string name);
        int base;
        reference();
        base = out_total;
        for (int c = N - 1; c >= 0; c--) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            for (int r = 0; r < N; r++) in_col[r] = img[r][c];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
        end
        // R2: no acceptance until this frame's outputs are all presented
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        checks++;
        if (out_total - base != N) begin
            errors++;
            $display("FAIL R3: frame %s outputs act=%0d exp=%0d", name, out_total - base, N);
        end
    endtask

    task automatic clear_img();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) img[r][c] = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: in_ready=%0b out_valid=%0b exp 1 0", in_ready, out_valid);
        end

        clear_img();
        send_frame("empty");

        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) img[r][c] = 1'b1;
        send_frame("full");

        // R9: empty frame after full must come out all zero
        clear_img();
        send_frame("empty_after_full");

        // R8: checkerboard, diagonal contacts only
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) img[r][c] = ((r + c) % 2 == 0);
        send_frame("checker");

        // R5: U closed on the left
        clear_img();
        for (int c = 1; c < N; c++) begin img[1][c] = 1'b1; img[6][c] = 1'b1; end
        for (int r = 1; r < 7; r++) img[r][1] = 1'b1;
        img[3][5] = 1'b1;
        send_frame("u_left");

        // R6: U closed on the right, arms split after the join leaves
        clear_img();
        for (int c = 0; c < N - 1; c++) begin img[2][c] = 1'b1; img[5][c] = 1'b1; end
        for (int r = 2; r < 6; r++) img[r][N-1] = 1'b1;
        img[0][0] = 1'b1;
        send_frame("u_right");

        // R7: serpentine, long flood paths
        clear_img();
        for (int r = 0; r < N; r += 2)
            for (int c = 0; c < N; c++) img[r][c] = 1'b1;
        img[1][N-1] = 1'b1; img[3][0] = 1'b1; img[5][N-1] = 1'b1;
        send_frame("serpentine");

        // mixed: corners, a bar, an L and diagonal neighbours
        clear_img();
        img[0][0] = 1'b1; img[0][N-1] = 1'b1; img[N-1][0] = 1'b1; img[N-1][N-1] = 1'b1;
        for (int r = 2; r < 6; r++) img[r][3] = 1'b1;
        img[1][4] = 1'b1;
        img[4][5] = 1'b1; img[4][6] = 1'b1; img[3][6] = 1'b1;
        img[6][2] = 1'b1;
        send_frame("mixed");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule